// File: doc/BRIEF.md
# Slot-Timed Power Sequencer

This block switches a bank of power resources (regulator enables, an oscillator enable, general-purpose enables) on and off in a fixed order. There are three independent sequencer groups. Each resource is tied to one group through its configuration register, or to no group. When a group's control level goes active, the group counts through eight time slots, and each resource in it switches on when the count reaches that resource's power-up slot. When the level goes inactive, the group counts again from slot 0, and each resource switches off at its own power-down slot.

Each group takes its control level from one of two external enable pins or from a software bit. The external pins pass through a two-flop synchronizer first. Slot length is a power-of-two multiple of a base period, counted in microsecond ticks. Each group stores two period codes, one for the shutdown transition and one for the suspend transition, and a mode input chooses which code applies. A group can also raise a sleep output or a global low-power output while its control level is active.

Top module: `pwrseq_top`

## Requirements
- R1: Register map on `wr_addr`. Addresses 0 to N_RES-1 hold resource configs: bits [1:0] are the group (0, 1, 2 select a group; 3 means no group), [4:2] the power-up slot, [7:5] the power-down slot, and [8] the direct enable. Addresses 8, 9 and 10 hold the configs of groups 0, 1 and 2: bits [1:0] are the source, [4:2] the shutdown period code, [7:5] the suspend period code, [8] the sleep enable and [9] the low-power enable. A write takes effect at the clock edge where `wr_en` is high. All registers reset to zero.
- R2: Group source code 0 selects synchronized `en_pin[0]`, code 1 selects synchronized `en_pin[1]`, code 2 selects `sw_ctl[g]` for group g, and code 3 keeps the group permanently inactive. A group ignores every input its code does not select.
- R3: A resource in group 3 (no group) ignores all sequencing, and its output equals its direct-enable bit one clock after that bit is written.
- R4: On a rising control level, a group's slot counter restarts at 0. A resource in that group turns on when the counter equals its power-up slot.
- R5: On a falling control level, the slot counter restarts at 0. A resource turns off when the counter equals its power-down slot.
- R6: One slot lasts BASE·2^code ticks of `us_tick`, where BASE is 40, or 20 when ALT_TABLE=1. The counter advances only on tick cycles and stops after slot 7.
- R7: When `susp_sel` is 0 the group's shutdown period code applies. When it is 1 the suspend period code applies.
- R8: `sleep_o` is high one clock after any group whose sleep enable is set has an active control level. `lpm_o` does the same with the low-power enable.
- R9: If the control level reverses before a sequence ends, the counter restarts at slot 0 in the new direction. Resources the old sequence had not reached keep their state.
- R10: An external enable pin affects a group's level two clocks after it changes, through a two-flop synchronizer. A software bit affects the level at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_pin | input | 2 | Asynchronous external enable pins |
| sw_ctl | input | 3 | Software control bit per group |
| susp_sel | input | 1 | 1 selects suspend period codes |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| res_en | output | N_RES | Per-resource enable |
| sleep_o | output | 1 | Sleep indication |
| lpm_o | output | 1 | Global low-power indication |

## Verification
The hardest case to reach is a direction reversal in the middle of a sequence. The bench drops the enable pin while the group sits in slot 1 of a power-up run. It then checks two things at a time chosen so that a design which kept counting up would already have switched on the slot-3 resource: that resource must still be off, and the slot-0 resource must stay on until slot 2 of the new power-down count. A second run in suspend mode shows that a different period code doubles both edges of the sequence.

// File: rtl/pwrseq_pkg.sv
// Shared types and helpers for the slot-timed power sequencer.
// Assumes three groups and 3-bit slot numbers.
package pwrseq_pkg;
    localparam int NUM_GRP = 3;
    localparam int SLOT_W  = 3;
    localparam int CNT_W   = 14;

    typedef struct packed {
        logic [1:0]        grp;
        logic [SLOT_W-1:0] up;
        logic [SLOT_W-1:0] dn;
        logic              direct;
    } res_cfg_t;

    typedef struct packed {
        logic [1:0] src;
        logic [2:0] per_sd;
        logic [2:0] per_ss;
        logic       slp;
        logic       lpm;
    } grp_cfg_t;

    // Slot length in ticks for a base period and a 3-bit code.
    function automatic logic [CNT_W-1:0] slot_ticks(input int base, input logic [2:0] code);
        logic [CNT_W-1:0] b;
        b = CNT_W'(base);
        return b << code;
    endfunction
endpackage

// File: rtl/pwrseq_regs.sv
// Configuration register file: per-resource and per-group settings.
// Assumes N_RES <= 8 so resource addresses stay below the group block at 8.
module pwrseq_regs
    import pwrseq_pkg::*;
#(
    parameter int N_RES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [15:0] wr_data,
    output res_cfg_t    res_cfg [N_RES],
    output grp_cfg_t    grp_cfg [NUM_GRP]
);
    genvar i;
    generate
        for (i = 0; i < N_RES; i++) begin : g_res
            // Capture one resource config word on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_cfg[i] <= '0;
                end else if (wr_en && wr_addr == 4'(i)) begin
                    res_cfg[i].grp    <= wr_data[1:0];
                    res_cfg[i].up     <= wr_data[4:2];
                    res_cfg[i].dn     <= wr_data[7:5];
                    res_cfg[i].direct <= wr_data[8];
                end
            end
        end
        for (i = 0; i < NUM_GRP; i++) begin : g_grp
            // Capture one group config word on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    grp_cfg[i] <= '0;
                end else if (wr_en && wr_addr == 4'(8 + i)) begin
                    grp_cfg[i].src    <= wr_data[1:0];
                    grp_cfg[i].per_sd <= wr_data[4:2];
                    grp_cfg[i].per_ss <= wr_data[7:5];
                    grp_cfg[i].slp    <= wr_data[8];
                    grp_cfg[i].lpm    <= wr_data[9];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/pwrseq_sync.sv
// Two-flop synchronizer for asynchronous level inputs.
// Assumes the inputs are slow levels; no pulse capture.
module pwrseq_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pwrseq_group.sv
// One sequencer group: finds edges on its control level and runs an
// eight-slot counter whose slot length comes from the given code.
// Assumes lvl is already synchronous.
module pwrseq_group
    import pwrseq_pkg::*;
#(
    parameter int BASE = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic              tick,
    input  logic [2:0]        code,
    output logic              run,
    output logic              dir,
    output logic [SLOT_W-1:0] slot,
    output logic              edge_o
);
    localparam logic [SLOT_W-1:0] LAST = '1;

    logic             lvl_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign edge_o = lvl ^ lvl_q;
    assign lim    = slot_ticks(BASE, code) - CNT_W'(1);

    // Level history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    // Slot counter: restart on an edge, step on ticks, stop after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 1'b0;
            dir  <= 1'b0;
            slot <= '0;
            cnt  <= '0;
        end else if (edge_o) begin
            run  <= 1'b1;
            dir  <= lvl;
            slot <= '0;
            cnt  <= '0;
        end else if (run && tick) begin
            if (cnt >= lim) begin
                cnt <= '0;
                if (slot == LAST) run  <= 1'b0;
                else              slot <= slot + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwrseq_top.sv
// Slot-timed power sequencer top: register file, pin synchronizer, three
// sequencer groups and per-resource enable registers.
// Assumes us_tick is a one-cycle pulse synchronous to clk.
module pwrseq_top
    import pwrseq_pkg::*;
#(
    parameter int N_RES     = 4,
    parameter bit ALT_TABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       en_pin,
    input  logic [2:0]       sw_ctl,
    input  logic             susp_sel,
    input  logic             us_tick,
    input  logic             wr_en,
    input  logic [3:0]       wr_addr,
    input  logic [15:0]      wr_data,
    output logic [N_RES-1:0] res_en,
    output logic             sleep_o,
    output logic             lpm_o
);
    localparam int BASE = ALT_TABLE ? 20 : 40;

    res_cfg_t                  res_cfg [N_RES];
    grp_cfg_t                  grp_cfg [NUM_GRP];
    logic [1:0]                pin_s;
    logic [NUM_GRP-1:0]        grp_lvl;
    logic [NUM_GRP-1:0]        grp_run;
    logic [NUM_GRP-1:0]        grp_dir;
    logic [NUM_GRP-1:0]        grp_edge;
    logic [NUM_GRP*SLOT_W-1:0] grp_slot;
    logic [NUM_GRP-1:0]        slp_req;
    logic [NUM_GRP-1:0]        lpm_req;
    logic [N_RES-1:0]          res_none;
    logic [N_RES-1:0]          res_dir;

    pwrseq_regs #(.N_RES(N_RES)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .res_cfg(res_cfg), .grp_cfg(grp_cfg)
    );

    pwrseq_sync #(.W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(en_pin), .q(pin_s)
    );

    genvar g, r;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            logic [2:0] code;

            // Pick the control level named by the source code.
            always_comb begin
                case (grp_cfg[g].src)
                    2'd0:    grp_lvl[g] = pin_s[0];
                    2'd1:    grp_lvl[g] = pin_s[1];
                    2'd2:    grp_lvl[g] = sw_ctl[g];
                    default: grp_lvl[g] = 1'b0;
                endcase
            end

            assign code       = susp_sel ? grp_cfg[g].per_ss : grp_cfg[g].per_sd;
            assign slp_req[g] = grp_lvl[g] & grp_cfg[g].slp;
            assign lpm_req[g] = grp_lvl[g] & grp_cfg[g].lpm;

            pwrseq_group #(.BASE(BASE)) u_grp (
                .clk(clk), .rst_n(rst_n), .lvl(grp_lvl[g]), .tick(us_tick),
                .code(code), .run(grp_run[g]), .dir(grp_dir[g]),
                .slot(grp_slot[g*SLOT_W +: SLOT_W]), .edge_o(grp_edge[g])
            );
        end

        for (r = 0; r < N_RES; r++) begin : g_res
            logic              sel_run;
            logic              sel_dir;
            logic [SLOT_W-1:0] sel_slot;

            // Route the bound group's state to this resource.
            always_comb begin
                sel_run  = 1'b0;
                sel_dir  = 1'b0;
                sel_slot = '0;
                for (int k = 0; k < NUM_GRP; k++) begin
                    if (res_cfg[r].grp == 2'(k)) begin
                        sel_run  = grp_run[k];
                        sel_dir  = grp_dir[k];
                        sel_slot = grp_slot[k*SLOT_W +: SLOT_W];
                    end
                end
            end

            assign res_none[r] = (res_cfg[r].grp == 2'd3);
            assign res_dir[r]  = res_cfg[r].direct;

            // Enable register: direct bit when unbound, else slot matches.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    res_en[r] <= 1'b0;
                end else if (res_none[r]) begin
                    res_en[r] <= res_cfg[r].direct;
                end else if (sel_run && sel_dir && sel_slot == res_cfg[r].up) begin
                    res_en[r] <= 1'b1;
                end else if (sel_run && !sel_dir && sel_slot == res_cfg[r].dn) begin
                    res_en[r] <= 1'b0;
                end
            end
        end
    endgenerate

    // Registered sleep and low-power indications.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_o <= 1'b0;
            lpm_o   <= 1'b0;
        end else begin
            sleep_o <= |slp_req;
            lpm_o   <= |lpm_req;
        end
    end
endmodule

// File: rtl/pwrseq_checker.sv
// Protocol checks for the power sequencer, attached by bind.
// Assumes packed group slot vector of three 3-bit fields.
module pwrseq_checker #(
    parameter int N_RES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             us_tick,
    input logic [2:0]       grp_run,
    input logic [2:0]       grp_edge,
    input logic [2:0]       grp_lvl,
    input logic [8:0]       grp_slot,
    input logic [N_RES-1:0] res_none,
    input logic [N_RES-1:0] res_dir,
    input logic [N_RES-1:0] res_en,
    input logic             sleep_o,
    input logic             lpm_o
);
    genvar g, r;
    generate
        for (g = 0; g < 3; g++) begin : g_chk
            AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
                grp_edge[g] |=> (grp_run[g] && grp_slot[g*3 +: 3] == 3'd0)); // R9
            AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (grp_run[g] && !grp_edge[g]) |=>
                (grp_slot[g*3 +: 3] == $past(grp_slot[g*3 +: 3]) ||
                 grp_slot[g*3 +: 3] == $past(grp_slot[g*3 +: 3]) + 3'd1)); // R6
            AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (!us_tick && !grp_edge[g]) |=> $stable(grp_slot[g*3 +: 3])); // R6
            AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
                (!grp_run[g] && !grp_edge[g]) |=> ($stable(grp_slot[g*3 +: 3]) && !grp_run[g])); // R6
        end
        for (r = 0; r < N_RES; r++) begin : g_rchk
            AST_NONE_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
                res_none[r] |=> (res_en[r] == $past(res_dir[r]))); // R3
        end
    endgenerate

    AST_SLEEP_NEEDS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> $past(|grp_lvl)); // R8
    AST_LPM_NEEDS_LVL: assert property (@(posedge clk) disable iff (!rst_n)
        lpm_o |-> $past(|grp_lvl)); // R8
endmodule

bind pwrseq_top pwrseq_checker #(.N_RES(N_RES)) u_chk (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .grp_run(grp_run),
    .grp_edge(grp_edge), .grp_lvl(grp_lvl), .grp_slot(grp_slot),
    .res_none(res_none), .res_dir(res_dir), .res_en(res_en),
    .sleep_o(sleep_o), .lpm_o(lpm_o)
);

// File: tb/sim_pwrseq_top.sv
// Scoreboard bench: the driver queues expected outputs, the monitor compares.
module sim_pwrseq_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  en_pin = '0;
    logic [2:0]  sw_ctl = '0;
    logic        susp_sel = 1'b0;
    logic        us_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  res_en;
    logic        sleep_o;
    logic        lpm_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] en;
        logic       slp;
        logic       lpm;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    pwrseq_top u0 (
        .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .sw_ctl(sw_ctl),
        .susp_sel(susp_sel), .us_tick(us_tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .res_en(res_en),
        .sleep_o(sleep_o), .lpm_o(lpm_o)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        idle(1);
        wr_en = 1'b0;
    endtask

    task automatic expect_out(input logic [3:0] e, input logic s, input logic l, input string tag);
        exp_t it;
        it.en = e; it.slp = s; it.lpm = l; it.tag = tag;
        exp_q.push_back(it);
        #0.1;
    endtask

    // Monitor: pop each expected item and compare at the same instant.
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            n_vec++;
            if (res_en !== it.en || sleep_o !== it.slp || lpm_o !== it.lpm) begin
                n_bad++;
                $display("FAIL %s: got en=%b slp=%b lpm=%b, expected en=%b slp=%b lpm=%b",
                         it.tag, res_en, sleep_o, lpm_o, it.en, it.slp, it.lpm);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    // Driver.
    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        expect_out(4'b0000, 1'b0, 1'b0, "R1 reset state");

        wr(4'd0, 16'h0040);   // grp0 up0 dn2
        wr(4'd1, 16'h000C);   // grp0 up3 dn0
        wr(4'd2, 16'h0025);   // grp1 up1 dn1
        wr(4'd3, 16'h0103);   // none, direct on
        wr(4'd8, 16'h0020);   // src EN0, shutdown code0, suspend code1
        wr(4'd9, 16'h0102);   // src SW, sleep
        wr(4'd10, 16'h0201);  // src EN1, low-power
        idle(1);
        expect_out(4'b1000, 1'b0, 1'b0, "R3 direct enable on");
        wr(4'd3, 16'h0003);
        idle(1);
        expect_out(4'b0000, 1'b0, 1'b0, "R3 direct enable off");

        // Power-up in shutdown mode: code 0 -> 40 ticks per slot.
        en_pin[0] = 1'b1;
        idle(100);
        expect_out(4'b0001, 1'b0, 1'b0, "R4 slot0 on, slot3 pending");
        idle(40);
        expect_out(4'b0011, 1'b0, 1'b0, "R4 slot3 on");
        idle(260);
        en_pin[0] = 1'b0;
        idle(20);
        expect_out(4'b0001, 1'b0, 1'b0, "R5 down slot0 off first");
        idle(80);
        expect_out(4'b0000, 1'b0, 1'b0, "R5 down slot2 off");
        idle(300);

        // Suspend mode: code 1 -> 80 ticks per slot.
        susp_sel = 1'b1;
        en_pin[0] = 1'b1;
        idle(200);
        expect_out(4'b0001, 1'b0, 1'b0, "R7 suspend period slot3 pending");
        idle(80);
        expect_out(4'b0011, 1'b0, 1'b0, "R7 suspend period slot3 on");
        idle(400);
        en_pin[0] = 1'b0;
        idle(100);
        expect_out(4'b0001, 1'b0, 1'b0, "R7 suspend down slot2 pending");
        idle(100);
        expect_out(4'b0000, 1'b0, 1'b0, "R6 suspend down done");
        idle(500);
        susp_sel = 1'b0;

        // Reversal in slot 1 of a power-up run.
        en_pin[0] = 1'b1;
        idle(60);
        expect_out(4'b0001, 1'b0, 1'b0, "R9 mid-sequence state");
        en_pin[0] = 1'b0;
        idle(40);
        expect_out(4'b0001, 1'b0, 1'b0, "R9 restarted at slot0");
        idle(30);
        expect_out(4'b0000 | 4'b0001, 1'b0, 1'b0, "R9 unreached slot3 stays off");
        idle(30);
        expect_out(4'b0000, 1'b0, 1'b0, "R9 down slot2 reached");
        idle(300);

        // Software-controlled group with sleep.
        sw_ctl[1] = 1'b1;
        idle(3);
        expect_out(4'b0000, 1'b1, 1'b0, "R8 sleep follows software level");
        idle(20);
        expect_out(4'b0000, 1'b1, 1'b0, "R10 slot1 pending");
        idle(30);
        expect_out(4'b0100, 1'b1, 1'b0, "R2 software source slot1 on");
        idle(300);
        sw_ctl[1] = 1'b0;
        idle(20);
        expect_out(4'b0100, 1'b0, 1'b0, "R8 sleep drops");
        idle(40);
        expect_out(4'b0000, 1'b0, 1'b0, "R5 software group down");
        idle(300);

        // Pin EN1 drives group 2 low-power only; group 0 ignores it.
        en_pin[1] = 1'b1;
        idle(1);
        expect_out(4'b0000, 1'b0, 1'b0, "R10 synchronizer delay");
        idle(4);
        expect_out(4'b0000, 1'b0, 1'b1, "R2 EN1 low-power, group0 unaffected");
        en_pin[1] = 1'b0;
        idle(5);
        expect_out(4'b0000, 1'b0, 1'b0, "R8 low-power drops");

        // Source code 3: group never activates.
        wr(4'd8, 16'h0023);
        en_pin[0] = 1'b1;
        idle(60);
        expect_out(4'b0000, 1'b0, 1'b0, "R2 source code 3 inactive");
        en_pin[0] = 1'b0;
        idle(5);

        wait (exp_q.size() == 0);
        idle(1);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule